// File: doc/BRIEF.md
# Two-Phase CCD Clock Sequencer

This block produces the digital timing pattern that clocks a small full-frame CCD: a complementary pair of vertical phases, a complementary pair of horizontal phases, a summing gate, a reset gate and a shutter-open flag. It also produces a one-cycle pixel-valid strobe for a downstream ADC, along with row and column indices. Level shifting to the analog rails is done outside the block.

A one-cycle `start` pulse in idle begins a frame. The frame first integrates for a programmed number of cycles with the shutter flag high, then reads the array out. In area-scan mode, each row is moved into the horizontal register and read out before the next row moves. In line-binning mode, every row is shifted down first and a single horizontal readout follows. All pulse widths and array sizes are parameters counted in system-clock cycles. Elaboration rejects any set of parameters that breaks the sensor minimums at the stated clock frequency:

- 1 µs vertical pulse.
- 500 ns horizontal half-period.
- 100 ns reset pulse.
- 3 µs settling before horizontal clocking.
- 1 MHz maximum pixel rate.

All pin outputs are registered.

Top module: `ccd_clock_seq`

## Requirements
- R1: After reset and in idle, the pins sit at rest: vPhase1=1, vPhase2=0, hPhase1=1, hPhase2=0, sumGate=0, resetGate=0, shutterOpen=0, pixValid=0, frameDone=0, rowIdx=0, colIdx=0.
- R2: A start pulse in idle captures intCycles and binMode. shutterOpen is then high for exactly max(intCycles,1) consecutive cycles. Changes to these inputs after the start pulse have no effect on the frame.
- R3: On every cycle, vPhase1 is the inverse of vPhase2, hPhase1 is the inverse of hPhase2, and sumGate equals hPhase2.
- R4: Each row transfer is one vPhase2 pulse of exactly V_HALF cycles, followed by at least V_HALF cycles with vPhase1 high. A frame contains exactly ROWS vPhase2 pulses.
- R5: After the last vPhase2 pulse before a horizontal readout falls, the first hPhase2 rise comes exactly V_HALF+GAP cycles later.
- R6: Each pixel period lasts 2*H_HALF cycles. hPhase2 is high for its first H_HALF cycles and hPhase1 for its last H_HALF cycles. resetGate is high for its first RG_W cycles.
- R7: pixValid is high for one cycle, in the last cycle of a pixel period, and only for column indices SKIP..COLS-1. While pixValid is high, colIdx gives the pixel's index in the line and rowIdx gives the row.
- R8: With binMode=0 (area scan), every row transfer is followed by a readout of COLS pixels, so a frame has ROWS*COLS pixel periods and rowIdx counts 0..ROWS-1.
- R9: With binMode=1 (line binning), all ROWS transfers run back to back, then one readout of COLS pixels follows, with rowIdx held at ROWS-1.
- R10: shutterOpen stays low for the whole readout. Readout lasts ROWS*(2*V_HALF+GAP+2*H_HALF*COLS) cycles in area scan and ROWS*2*V_HALF+GAP+2*H_HALF*COLS cycles in line binning, counted from the first cycle with shutterOpen low.
- R11: frameDone is a single-cycle pulse in the cycle right after the readout ends, with every other pin at its R1 rest level. The block is idle afterwards.
- R12: A start pulse outside idle is ignored: no new integration follows the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request pulse, honoured only in idle |
| binMode | input | 1 | 0 = area scan, 1 = line binning |
| intCycles | input | INT_W | Integration length in clock cycles (0 acts as 1) |
| vPhase1 | output | 1 | Vertical phase 1 |
| vPhase2 | output | 1 | Vertical phase 2 |
| hPhase1 | output | 1 | Horizontal phase 1 |
| hPhase2 | output | 1 | Horizontal phase 2 |
| sumGate | output | 1 | Summing gate, same waveform as hPhase2 |
| resetGate | output | 1 | Output-node reset pulse |
| shutterOpen | output | 1 | High only during integration |
| pixValid | output | 1 | ADC sample strobe for active pixels |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| rowIdx | output | ROW_W | Current row index |
| colIdx | output | COL_W | Current pixel index within the line |

## Verification
The embedded assertions watch the pin-level timing rules on every cycle:

- the exact vPhase2 pulse width;
- the settling distance from a vPhase2 fall to the next hPhase2 rise;
- the reset-pulse width;
- the summing gate tracking hPhase2;
- no horizontal activity while the shutter is open;
- the strobe never overlapping the reset pulse;
- the rest state at frameDone;
- the refusal of start outside idle.

Only the bench scenarios can show the per-frame properties:

- integration length for zero and non-zero settings;
- the number of transfers and pixels in each mode;
- the column and row sequence on strobed pixels;
- the total readout length;
- that a mid-frame start leaves the block quiet after the frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_VXFER,
    ST_VHOLD,
    ST_GAP,
    ST_HREAD,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic tickClr;
    logic colInc;
    logic colClr;
    logic rowInc;
    logic rowClr;
  } seqStrobe_t;

endpackage

// File: rtl/ccd_seq_count.sv
module ccd_seq_count
  import ccd_seq_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic [TICK_W-1:0] tick,
  output logic [COL_W-1:0]  colCnt,
  output logic [ROW_W-1:0]  rowCnt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick <= '0;
    end else if (strobe.tickClr) begin
      tick <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
    end else if (strobe.colClr) begin
      colCnt <= '0;
    end else if (strobe.colInc) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
    end else if (strobe.rowClr) begin
      rowCnt <= '0;
    end else if (strobe.rowInc) begin
      rowCnt <= rowCnt + 1'b1;
    end
  end

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
  import ccd_seq_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int TICK_W = 24,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 6,
  parameter int COLS   = 232,
  parameter int ROWS   = 56,
  parameter int SKIP   = 16,
  parameter int V_HALF = 100,
  parameter int GAP    = 150,
  parameter int H_HALF = 313,
  parameter int RG_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              binMode,
  input  logic [INT_W-1:0]  intCycles,
  input  logic [TICK_W-1:0] tick,
  input  logic [COL_W-1:0]  colCnt,
  input  logic [ROW_W-1:0]  rowCnt,
  output seqStrobe_t        strobe,
  output logic              vPhase1,
  output logic              vPhase2,
  output logic              hPhase1,
  output logic              hPhase2,
  output logic              sumGate,
  output logic              resetGate,
  output logic              shutterOpen,
  output logic              pixValid,
  output logic              frameDone
);

  localparam logic [TICK_W-1:0] V_LAST   = TICK_W'(V_HALF - 1);
  localparam logic [TICK_W-1:0] GAP_LAST = TICK_W'(GAP - 1);
  localparam logic [TICK_W-1:0] PIX_LAST = TICK_W'(2 * H_HALF - 1);
  localparam logic [TICK_W-1:0] H_SPLIT  = TICK_W'(H_HALF);
  localparam logic [TICK_W-1:0] RG_END   = TICK_W'(RG_W);
  localparam logic [COL_W-1:0]  COL_END  = COL_W'(COLS - 1);
  localparam logic [COL_W-1:0]  COL_SKIP = COL_W'(SKIP);
  localparam logic [ROW_W-1:0]  ROW_END  = ROW_W'(ROWS - 1);

  seqState_t        state, stateNext;
  logic             binQ;
  logic [INT_W-1:0] intLastQ;
  logic             rowLast, colLast, hRun;

  assign rowLast = (rowCnt == ROW_END);
  assign colLast = (colCnt == COL_END);
  assign hRun    = (state == ST_HREAD);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.tickClr = 1'b1;
        strobe.colClr  = 1'b1;
        strobe.rowClr  = 1'b1;
        if (start) stateNext = ST_INTEG;
      end
      ST_INTEG: begin
        if (tick == TICK_W'(intLastQ)) begin
          strobe.tickClr = 1'b1;
          stateNext      = ST_VXFER;
        end
      end
      ST_VXFER: begin
        if (tick == V_LAST) begin
          strobe.tickClr = 1'b1;
          stateNext      = ST_VHOLD;
        end
      end
      ST_VHOLD: begin
        if (tick == V_LAST) begin
          strobe.tickClr = 1'b1;
          if (!binQ || rowLast) begin
            stateNext = ST_GAP;
          end else begin
            strobe.rowInc = 1'b1;
            stateNext     = ST_VXFER;
          end
        end
      end
      ST_GAP: begin
        if (tick == GAP_LAST) begin
          strobe.tickClr = 1'b1;
          stateNext      = ST_HREAD;
        end
      end
      ST_HREAD: begin
        if (tick == PIX_LAST) begin
          strobe.tickClr = 1'b1;
          if (colLast) begin
            strobe.colClr = 1'b1;
            if (!binQ && !rowLast) begin
              strobe.rowInc = 1'b1;
              stateNext     = ST_VXFER;
            end else begin
              strobe.rowClr = 1'b1;
              stateNext     = ST_FIN;
            end
          end else begin
            strobe.colInc = 1'b1;
          end
        end
      end
      ST_FIN: begin
        strobe.tickClr = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      binQ     <= 1'b0;
      intLastQ <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) begin
        binQ     <= binMode;
        intLastQ <= (intCycles == '0) ? '0 : intCycles - 1'b1;
      end
    end
  end

  // Registered pin stage: decode of the current state and counters.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPhase1     <= 1'b1;
      vPhase2     <= 1'b0;
      hPhase1     <= 1'b1;
      hPhase2     <= 1'b0;
      sumGate     <= 1'b0;
      resetGate   <= 1'b0;
      shutterOpen <= 1'b0;
      pixValid    <= 1'b0;
      frameDone   <= 1'b0;
    end else begin
      vPhase2     <= (state == ST_VXFER);
      vPhase1     <= (state != ST_VXFER);
      hPhase2     <= hRun && (tick < H_SPLIT);
      hPhase1     <= !(hRun && (tick < H_SPLIT));
      sumGate     <= hRun && (tick < H_SPLIT);
      resetGate   <= hRun && (tick < RG_END);
      shutterOpen <= (state == ST_INTEG);
      pixValid    <= hRun && (tick == PIX_LAST) && (colCnt >= COL_SKIP);
      frameDone   <= (state == ST_FIN);
    end
  end

  // R12: once a frame runs, integration is entered only from idle.
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_INTEG) |=> (state != ST_INTEG));

  // R2: integration never outlasts the captured length.
  assert_integ_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INTEG) |-> (tick <= TICK_W'(intLastQ)));

endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq
  import ccd_seq_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int INT_W   = 24,
  parameter int COLS    = 232,
  parameter int ROWS    = 56,
  parameter int SKIP    = 16,
  parameter int V_HALF  = 100,
  parameter int GAP     = 150,
  parameter int H_HALF  = 313,
  parameter int RG_W    = 10,
  localparam int MAXSEG = (V_HALF > GAP)
                          ? ((V_HALF > 2 * H_HALF) ? V_HALF : 2 * H_HALF)
                          : ((GAP > 2 * H_HALF) ? GAP : 2 * H_HALF),
  localparam int SEG_W  = $clog2(MAXSEG + 1),
  localparam int TICK_W = (INT_W > SEG_W) ? INT_W : SEG_W,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             binMode,
  input  logic [INT_W-1:0] intCycles,
  output logic             vPhase1,
  output logic             vPhase2,
  output logic             hPhase1,
  output logic             hPhase2,
  output logic             sumGate,
  output logic             resetGate,
  output logic             shutterOpen,
  output logic             pixValid,
  output logic             frameDone,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx
);

  // Elaboration-time timing checks against the sensor minimums.
  if (V_HALF < CLK_MHZ) begin : g_bad_vwidth
    $error("vertical pulse shorter than 1 us");
  end
  if (2 * H_HALF < CLK_MHZ) begin : g_bad_hwidth
    $error("horizontal half-period under 500 ns or pixel rate above 1 MHz");
  end
  if (RG_W * 10 < CLK_MHZ || RG_W < 1) begin : g_bad_rg
    $error("reset pulse shorter than 100 ns");
  end
  if (V_HALF + GAP < 3 * CLK_MHZ || GAP < 1) begin : g_bad_gap
    $error("settling before horizontal clocking under 3 us");
  end
  if (RG_W + 1 >= 2 * H_HALF) begin : g_bad_strobe
    $error("no room for the pixel strobe after the reset pulse");
  end
  if (SKIP >= COLS || ROWS < 2 || COLS < 2) begin : g_bad_array
    $error("array geometry out of range");
  end

  seqStrobe_t        strobe;
  logic [TICK_W-1:0] tick;
  logic [COL_W-1:0]  colCnt;
  logic [ROW_W-1:0]  rowCnt;

  ccd_seq_count #(
    .TICK_W(TICK_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tick(tick), .colCnt(colCnt), .rowCnt(rowCnt)
  );

  ccd_seq_fsm #(
    .INT_W(INT_W), .TICK_W(TICK_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .COLS(COLS), .ROWS(ROWS), .SKIP(SKIP), .V_HALF(V_HALF),
    .GAP(GAP), .H_HALF(H_HALF), .RG_W(RG_W)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .start(start), .binMode(binMode),
    .intCycles(intCycles), .tick(tick), .colCnt(colCnt), .rowCnt(rowCnt),
    .strobe(strobe), .vPhase1(vPhase1), .vPhase2(vPhase2),
    .hPhase1(hPhase1), .hPhase2(hPhase2), .sumGate(sumGate),
    .resetGate(resetGate), .shutterOpen(shutterOpen),
    .pixValid(pixValid), .frameDone(frameDone)
  );

  // Indices delayed to line up with the registered pin stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowIdx <= '0;
      colIdx <= '0;
    end else begin
      rowIdx <= rowCnt;
      colIdx <= colCnt;
    end
  end

  // Pin-level run counters used only by the assertions below.
  int v2Run, sinceV2, rgRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      v2Run   <= 0;
      sinceV2 <= 0;
      rgRun   <= 0;
    end else begin
      v2Run   <= vPhase2 ? v2Run + 1 : 0;
      sinceV2 <= vPhase2 ? 0 : ((sinceV2 < 32'h3fff_ffff) ? sinceV2 + 1 : sinceV2);
      rgRun   <= resetGate ? rgRun + 1 : 0;
    end
  end

  assert_sg_follows_h2_R3: assert property (@(posedge clk) disable iff (!rstN)
    sumGate == hPhase2);

  assert_v2_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vPhase2) |-> (v2Run == V_HALF));

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hPhase2) |-> (sinceV2 >= V_HALF + GAP));

  assert_rg_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetGate) |-> (rgRun == RG_W));

  assert_strobe_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (!resetGate && hPhase1));

  assert_shutter_dark_R10: assert property (@(posedge clk) disable iff (!rstN)
    shutterOpen |-> (!hPhase2 && !resetGate && !vPhase2 && !pixValid));

  assert_done_rest_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (vPhase1 && !vPhase2 && hPhase1 && !hPhase2 && !resetGate
                   && !shutterOpen && !pixValid && rowIdx == '0 && colIdx == '0));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

// File: tb/sim_ccd_clock_seq.sv
module sim_ccd_clock_seq;

  localparam int CLK_MHZ = 50;
  localparam int INT_W   = 12;
  localparam int COLS    = 6;
  localparam int ROWS    = 3;
  localparam int SKIP    = 2;
  localparam int V_HALF  = 50;
  localparam int GAP     = 100;
  localparam int H_HALF  = 25;
  localparam int RG_W    = 5;
  localparam int COL_W   = 3;
  localparam int ROW_W   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic binMode = 1'b0;
  logic [INT_W-1:0] intCycles = '0;
  logic vPhase1, vPhase2, hPhase1, hPhase2, sumGate, resetGate;
  logic shutterOpen, pixValid, frameDone;
  logic [ROW_W-1:0] rowIdx;
  logic [COL_W-1:0] colIdx;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ccd_clock_seq #(
    .CLK_MHZ(CLK_MHZ), .INT_W(INT_W), .COLS(COLS), .ROWS(ROWS), .SKIP(SKIP),
    .V_HALF(V_HALF), .GAP(GAP), .H_HALF(H_HALF), .RG_W(RG_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .binMode(binMode),
    .intCycles(intCycles), .vPhase1(vPhase1), .vPhase2(vPhase2),
    .hPhase1(hPhase1), .hPhase2(hPhase2), .sumGate(sumGate),
    .resetGate(resetGate), .shutterOpen(shutterOpen), .pixValid(pixValid),
    .frameDone(frameDone), .rowIdx(rowIdx), .colIdx(colIdx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit atRest();
    return vPhase1 && !vPhase2 && hPhase1 && !hPhase2 && !sumGate && !resetGate
           && !shutterOpen && !pixValid && !frameDone && rowIdx == 0 && colIdx == 0;
  endfunction

  task automatic runFrame(input bit mode, input int n);
    int shutCnt = 0, compErr = 0, shutErr = 0, lateShut = 0;
    int v2Pulses = 0, v2Run = 0, v2Err = 0;
    int h2Pulses = 0, h2Run = 0, h2Err = 0;
    int rgPulses = 0, rgRun = 0, rgErr = 0;
    int sinceV2 = 0, gapErr = 0, gapSeen = 0;
    int pixPos = 1000, validCnt = 0, idxErr = 0, posErr = 0;
    int readIdx = 0, doneAt = -1, doneCnt = 0, restErr = 0, quiet = 0;
    int expN, expPix, expValid, expRead, guard = 0;
    bit seenRead = 0, armed = 0, prevV2 = 0, prevH2 = 0, prevRg = 0;
    expN     = (n == 0) ? 1 : n;
    expPix   = mode ? COLS : ROWS * COLS;
    expValid = mode ? (COLS - SKIP) : ROWS * (COLS - SKIP);
    expRead  = mode ? (ROWS * 2 * V_HALF + GAP + 2 * H_HALF * COLS)
                    : ROWS * (2 * V_HALF + GAP + 2 * H_HALF * COLS);
    @(negedge clk);
    start = 1'b1; binMode = mode; intCycles = INT_W'(n);
    @(negedge clk);
    start = 1'b0; binMode = ~mode; intCycles = '1;   // R2: late changes ignored
    while (guard < 6000) begin
      guard++;
      if (vPhase1 == vPhase2 || hPhase1 == hPhase2 || sumGate != hPhase2) compErr++;
      if (shutterOpen) begin
        shutCnt++;
        if (seenRead) lateShut++;
        if (hPhase2 || resetGate || vPhase2 || pixValid) shutErr++;
      end
      if (seenRead) readIdx++;
      else if (!shutterOpen && shutCnt > 0) begin seenRead = 1; readIdx = 0; end
      start = (seenRead && readIdx == 20);   // R12: start during readout
      sinceV2++;
      if (vPhase2 && !prevV2) begin v2Pulses++; v2Run = 1; end
      else if (vPhase2) v2Run++;
      if (!vPhase2 && prevV2) begin
        if (v2Run != V_HALF) v2Err++;
        armed = 1; sinceV2 = 0;
      end
      pixPos++;
      if (hPhase2 && !prevH2) begin
        h2Pulses++; h2Run = 1; pixPos = 0;
        if (armed) begin
          if (sinceV2 != V_HALF + GAP) gapErr++;
          gapSeen++; armed = 0;
        end
      end else if (hPhase2) h2Run++;
      if (!hPhase2 && prevH2 && h2Run != H_HALF) h2Err++;
      if (resetGate && !prevRg) begin rgPulses++; rgRun = 1; end
      else if (resetGate) rgRun++;
      if (!resetGate && prevRg && rgRun != RG_W) rgErr++;
      if (resetGate && !hPhase2) rgErr++;
      if (pixValid) begin
        if (colIdx != SKIP + (validCnt % (COLS - SKIP))) idxErr++;
        if (rowIdx != (mode ? ROWS - 1 : validCnt / (COLS - SKIP))) idxErr++;
        if (pixPos != 2 * H_HALF - 1 || resetGate) posErr++;
        validCnt++;
      end
      if (frameDone) begin
        doneCnt++; doneAt = readIdx;
        if (!(vPhase1 && !vPhase2 && hPhase1 && !hPhase2 && !resetGate && !shutterOpen
              && !pixValid && rowIdx == 0 && colIdx == 0)) restErr++;
      end else if (doneCnt > 0) begin
        break;
      end
      prevV2 = vPhase2; prevH2 = hPhase2; prevRg = resetGate;
      @(negedge clk);
    end
    start = 1'b0;
    for (int q = 0; q < 60; q++) begin
      if (shutterOpen || vPhase2 || hPhase2 || resetGate || frameDone) quiet++;
      @(negedge clk);
    end
    chk(guard < 6000, "R11 frame ended", guard, 6000);
    chk(shutCnt == expN, "R2 integration length", shutCnt, expN);
    chk(compErr == 0, "R3 complementary phases", compErr, 0);
    chk(v2Pulses == ROWS, "R4 transfer count", v2Pulses, ROWS);
    chk(v2Err == 0, "R4 vertical width", v2Err, 0);
    chk(gapErr == 0 && gapSeen == (mode ? 1 : ROWS), "R5 settling gap", gapSeen, mode ? 1 : ROWS);
    chk(h2Err == 0 && rgErr == 0 && rgPulses == h2Pulses, "R6 pixel waveform", h2Err + rgErr, 0);
    chk(validCnt == expValid, "R7 strobe count", validCnt, expValid);
    chk(idxErr == 0 && posErr == 0, "R7 strobe index/position", idxErr + posErr, 0);
    if (mode) chk(h2Pulses == expPix, "R9 binning pixel count", h2Pulses, expPix);
    else      chk(h2Pulses == expPix, "R8 area pixel count", h2Pulses, expPix);
    chk(shutErr == 0, "R10 shutter dark during readout", shutErr, 0);
    chk(doneAt == expRead, "R10 readout length", doneAt, expRead);
    chk(doneCnt == 1 && restErr == 0, "R11 done pulse at rest", doneCnt, 1);
    chk(lateShut == 0 && quiet == 0, "R12 mid-frame start ignored", lateShut + quiet, 0);
    chk(atRest(), "R1 idle after frame", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(atRest(), "R1 reset state", 0, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(atRest(), "R1 idle after reset", 0, 1);
    runFrame(1'b0, 0);
    runFrame(1'b0, 1);
    runFrame(1'b0, 37);
    runFrame(1'b1, 0);
    runFrame(1'b1, 5);
    runFrame(1'b1, 200);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule